// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block is a parameterised chain of scan flip-flops with a small controller that runs a complete scan test on its own. Each flip-flop in the chain can take one of two inputs. In normal operation it loads its own bit of a functional parallel input. In shift mode it loads the output of the stage before it. Stage 0 takes the serial input, and the last stage drives the serial output.

A one-cycle start pulse launches a test. The controller shifts a test vector in serially over N cycles. It then spends one cycle with shift mode off, so the chain captures the functional inputs, which carry the response of the logic under test. Finally it shifts that captured response out serially over N cycles.

A back-to-back mode lets the unload of one response also load the next vector. The controller then returns straight to capture, and a chain of tests runs without gaps. The block has a single edge-triggered clock and a synchronous active-high reset.

Top module: `scan_seq_top`

## Requirements
- R1: A synchronous reset clears every chain stage, so `func_out` and `scan_out` read 0. It returns the controller to idle, so `busy` and `done` read 0 in the cycle after the reset edge.
- R2: While idle, every stage loads its own bit of `func_in` at each clock edge, so `func_out` equals the `func_in` of the previous cycle.
- R3: During shift cycles, stage i loads stage i-1 and stage 0 loads `scan_in`, with `func_in` ignored. `scan_out` is always the last stage, bit N-1. Bits sent most significant first over the N load cycles appear as the full vector on `func_out` in the capture cycle.
- R4: A start pulse seen while idle raises `busy` in the next cycle. A test occupies exactly N load cycles, one capture cycle and N unload cycles. `busy` is high in all of them and low in the cycle after the last unload cycle.
- R5: In the capture cycle the chain loads `func_in`. The captured word leaves on `scan_out` most significant bit first: bit N-1-m appears in unload cycle m, for m = 0 to N-1.
- R6: `done` is high for exactly one cycle, the cycle after the last unload cycle, and low at all other times.
- R7: A start pulse while `busy` is high is ignored, and the running test keeps its timing.
- R8: If `chain_b2b` is high at the final unload edge, the bits shifted in during the unload become the next vector. In that case the controller goes straight to capture, `busy` stays high, and `done` still pulses in that capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one test when idle |
| chain_b2b | input | 1 | Continue into the next capture after the unload |
| func_in | input | CHAIN_LEN | Functional parallel inputs of the stages |
| func_out | output | CHAIN_LEN | Stage contents, bit i is stage i |
| scan_in | input | 1 | Serial input into stage 0 |
| scan_out | output | 1 | Serial output from the last stage |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse after the last unload bit |

## Verification
On every cycle, the assertions check the following local relations. In shift cycles the chain moves one place with `scan_in` entering stage 0. An idle chain follows `func_in`. `scan_out` always taps the last stage. `done` only follows a busy cycle and never lasts two cycles. A reset clears the chain. Several properties only the bench scenarios can show: the exact N + 1 + N cycle count, the bit order on the way in and out, start being ignored mid-test, and the seamless chaining of vectors and responses in back-to-back mode.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_CAPT   = 2'd2,
    ST_UNLOAD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic par_d,
  input  logic ser_d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (shift_en) q <= ser_d;
    else               q <= par_d;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 ser_in,
  input  logic [CHAIN_LEN-1:0] par_in,
  output logic [CHAIN_LEN-1:0] stage_q
);
  logic [CHAIN_LEN:0] link;
  assign link[0] = ser_in;

  for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_stage
    scan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .par_d    (par_in[g]),
      .ser_d    (link[g]),
      .q        (stage_q[g])
    );
    assign link[g+1] = stage_q[g];
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic chain_b2b,
  output logic shift_en,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

  seq_state_t state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAPT: begin
          cnt   <= '0;
          state <= ST_UNLOAD;
        end
        ST_UNLOAD: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            done  <= 1'b1;
            state <= chain_b2b ? ST_CAPT : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign shift_en = (state == ST_LOAD) || (state == ST_UNLOAD);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 chain_b2b,
  input  logic [CHAIN_LEN-1:0] func_in,
  output logic [CHAIN_LEN-1:0] func_out,
  input  logic                 scan_in,
  output logic                 scan_out,
  output logic                 busy,
  output logic                 done
);
  logic scan_en;

  scan_ctrl #(.CHAIN_LEN(CHAIN_LEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .chain_b2b (chain_b2b),
    .shift_en  (scan_en),
    .busy      (busy),
    .done      (done)
  );

  scan_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (scan_en),
    .ser_in   (scan_in),
    .par_in   (func_in),
    .stage_q  (func_out)
  );

  assign scan_out = func_out[CHAIN_LEN-1];
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 scan_in,
  input logic [CHAIN_LEN-1:0] func_in,
  input logic [CHAIN_LEN-1:0] func_out,
  input logic                 scan_out,
  input logic                 busy,
  input logic                 done,
  input logic                 scan_en
);
  logic [CHAIN_LEN-1:0] shifted;
  logic rst_q;

  assign shifted = CHAIN_LEN'({func_out, scan_in});

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R1: assert (func_out == '0 && !busy && !done)
        else $error("chain or controller not cleared by reset");
    end
  end

  always_comb begin
    assert_tap_last_R3: assert (scan_out === func_out[CHAIN_LEN-1] || $isunknown(func_out))
      else $error("scan_out does not tap last stage");
  end

  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> func_out == $past(func_in))
    else $error("idle chain did not follow func_in");

  assert_shift_move_R3: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> func_out == $past(shifted))
    else $error("chain did not shift by one place");

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy)
    else $error("start did not raise busy");

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done held longer than one cycle");

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy))
    else $error("done without a preceding busy cycle");
endmodule

bind scan_seq_top scan_seq_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (.*);

// File: tb/tb_scan_seq_top.sv
`timescale 1ns/1ps
module tb_scan_seq_top;
  localparam int N = 8;

  typedef struct {
    int          sig;
    logic [N-1:0] val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic chain_b2b = 1'b0;
  logic [N-1:0] func_in = 8'hA5;
  logic [N-1:0] func_out;
  logic scan_in = 1'b0;
  logic scan_out;
  logic busy;
  logic done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  scan_seq_top #(.CHAIN_LEN(N)) dut (
    .clk(clk), .rst(rst), .start(start), .chain_b2b(chain_b2b),
    .func_in(func_in), .func_out(func_out), .scan_in(scan_in),
    .scan_out(scan_out), .busy(busy), .done(done)
  );

  // sig codes: 0 scan_out, 1 busy, 2 done, 3 func_out
  task automatic expect_v(input int sig, input logic [N-1:0] val, input string tag);
    exp_t e;
    e.sig = sig; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [N-1:0] act;
        e = q.pop_front();
        case (e.sig)
          0: act = N'(scan_out);
          1: act = N'(busy);
          2: act = N'(done);
          default: act = func_out;
        endcase
        total++;
        if (act !== e.val) begin
          bad++;
          $display("FAIL %s sig=%0d actual=%h expected=%h at %0t", e.tag, e.sig, act, e.val, $time);
        end
      end
    end
  end

  task automatic run_seq(input logic [N-1:0] vecs[3], input logic [N-1:0] resps[3],
                         input int cnt, input bit poke_start);
    @(negedge clk);
    start = 1'b1; chain_b2b = (cnt > 1); func_in = ~resps[0];
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      expect_v(1, 1, "R4 busy in load");
      expect_v(2, 0, "R6 done low in load");
      scan_in = vecs[0][N-1-k];
      start = (poke_start && k == 2);   // R7: ignored while busy
      func_in = ~resps[0] ^ N'(k);      // R3: ignored while shifting
    end
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      expect_v(3, vecs[i], (i == 0) ? "R3 vector in capture" : "R8 chained vector");
      expect_v(1, 1, "R4 busy in capture");
      expect_v(2, (i > 0) ? 1 : 0, "R6 R8 done at chained capture");
      start = 1'b0;
      func_in = resps[i];
      chain_b2b = (i < cnt - 1);
      for (int m = 0; m < N; m++) begin
        @(negedge clk);
        expect_v(0, N'(resps[i][N-1-m]), "R5 unload bit");
        expect_v(1, 1, "R4 busy in unload");
        expect_v(2, 0, "R6 done low in unload");
        func_in = ~resps[i];
        scan_in = (i + 1 < cnt) ? vecs[i+1][N-1-m] : 1'b0;
      end
    end
    @(negedge clk);
    expect_v(2, 1, "R6 done pulse");
    expect_v(1, 0, "R4 busy low after unload");
    chain_b2b = 1'b0;
    @(negedge clk);
    expect_v(2, 0, "R6 done one cycle");
  endtask

  initial begin
    logic [N-1:0] v[3];
    logic [N-1:0] r[3];
    repeat (3) @(negedge clk);
    expect_v(3, 0, "R1 reset chain");
    expect_v(0, 0, "R1 reset scan_out");
    expect_v(1, 0, "R1 reset busy");
    expect_v(2, 0, "R1 reset done");
    rst = 1'b0;
    func_in = 8'h3C;
    @(negedge clk);
    expect_v(3, 8'h3C, "R2 idle load");
    func_in = 8'hC3;
    @(negedge clk);
    expect_v(3, 8'hC3, "R2 idle load");
    expect_v(1, 0, "R2 idle not busy");

    v = '{8'hB4, 8'h00, 8'h00};
    r = '{8'h69, 8'h00, 8'h00};
    run_seq(v, r, 1, 1'b1);

    v = '{8'h81, 8'h7E, 8'hFF};
    r = '{8'h0F, 8'hA0, 8'h01};
    run_seq(v, r, 3, 1'b0);

    // reset in the middle of a load
    @(negedge clk);
    start = 1'b1; scan_in = 1'b1;
    repeat (4) begin
      @(negedge clk);
      start = 1'b0;
    end
    rst = 1'b1;
    @(negedge clk);
    expect_v(3, 0, "R1 mid-test reset chain");
    expect_v(1, 0, "R1 mid-test reset busy");
    expect_v(0, 0, "R1 mid-test reset scan_out");
    rst = 1'b0; scan_in = 1'b0;

    v = '{8'h5A, 8'h00, 8'h00};
    r = '{8'hE7, 8'h00, 8'h00};
    run_seq(v, r, 1, 1'b0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule